// File: doc/BRIEF.md
# Page-Mode Read Sequencer for External Asynchronous Memory

This block performs reads from an asynchronous page-mode memory on an external bus. A client offers a read through a valid/ready handshake that carries a word address and byte enables. The block lowers chip select and the read strobe together and drives the address and byte-select lines. It holds the strobes for a programmed number of clocks, samples the 16-bit data bus on the final clock of that pulse, and returns the word with a single-cycle valid pulse.

The memory serves words from an open page faster than it opens a new page. The address therefore splits in two. The upper bits name the page and the lowest `PAGE_BITS` bits pick a word inside it. When the next request is already waiting as an access ends, and it names the same page, the block starts the next access at once with the shorter subsequent-access pulse. The strobes stay low throughout. Any other request opens a new page. The strobes first go high for at least one clock, and then the first-access pulse is applied. There are no setup or hold phases, so the strobes fall on the clock after a request is accepted.

Top module: `pmrd_seq`

## Requirements
- R1: After reset, chip select, read strobe and all byte-select lines are high (inactive), `reqReady` is 1 and `rspValid` is 0.
- R2: Read strobe and chip select always carry the same level. Across a run of page hits they stay low without a single high cycle.
- R3: An access that opens a page holds the strobes low for `cfgFirstPulse` clocks, starting on the clock after the request is accepted.
- R4: A request is a page hit when it is valid on the last clock of an ongoing access and its address above the low `PAGE_BITS` bits matches that access. A hit holds the strobes low for `cfgNextPulse` clocks.
- R5: The two pulse values are applied exactly as programmed with no cross-check, including when `cfgNextPulse` is larger than `cfgFirstPulse`.
- R6: A pulse value of 0 behaves as a pulse of 1 clock.
- R7: When an access ends with no request waiting, or with a request for another page, the strobes go high for at least one clock before the next page opens. That next access uses the first-access pulse.
- R8: During an access, `memAddr` shows the full accepted address. The upper bits select the page and the low `PAGE_BITS` bits select the word.
- R9: Byte selects are active low. With `cfgByteSel`=1 they show the inverted byte enables of the request during its access. With `cfgByteSel`=0 they are all low during every access. Between accesses they are all high.
- R10: `memData` is sampled on the last low clock of each access. It appears on `rspData` with `rspValid` high for one clock on the following cycle, one response per accepted request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Request taken on this clock when valid |
| reqAddr | input | ADDR_W | Word address of the request |
| reqByteEn | input | DATA_W/8 | Byte enables of the request (1 = byte wanted) |
| cfgFirstPulse | input | PULSE_W | Strobe length in clocks for the first access to a page |
| cfgNextPulse | input | PULSE_W | Strobe length in clocks for page hits |
| cfgByteSel | input | 1 | 1 = byte selects follow byte enables, 0 = all bytes selected |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| memAddr | output | ADDR_W | Address bus to the memory |
| bsN | output | DATA_W/8 | Byte-select lines, active low |
| memData | input | DATA_W | Data bus from the memory |
| rspValid | output | 1 | One-clock pulse marking returned data |
| rspData | output | DATA_W | Returned read data |

## Verification
Hit and miss depend on timing as well as on the address. A request to the same page counts as a hit only if it is already waiting on the last clock of the running access, so the hardest case to reach is a long back-to-back page burst. The driver handles this by offering each next request on the clock after the previous one is taken and holding it until it is accepted. Separate calls insert idle gaps longer than any pulse, so that same-page requests also arrive after the strobes have risen. The monitor measures every low run of the strobes and notes whether the run began after a high clock. From this it sees both the pulse length and whether the block treated the access as a hit.

// File: rtl/pmrd_pkg.sv
package pmrd_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;     // request accepted this clock
    logic capture;  // last low clock of the current access
    logic active;   // strobes are asserted
  } ctrlStrb_t;
endpackage

// File: rtl/pmrd_ctrl.sv
module pmrd_ctrl
  import pmrd_pkg::*;
#(
  parameter int PULSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic               pageHit,
  input  logic [PULSE_W-1:0] cfgFirstPulse,
  input  logic [PULSE_W-1:0] cfgNextPulse,
  output logic               reqReady,
  output ctrlStrb_t          strb
);
  logic               activeQ;
  logic [PULSE_W-1:0] cntQ;
  logic               lastCycle;
  logic               accept;
  logic [PULSE_W-1:0] pulseLen;
  logic [PULSE_W-1:0] loadVal;

  assign lastCycle = activeQ && (cntQ == '0);
  // idle: always ready; busy: only a page hit on the final clock
  assign reqReady  = !activeQ || (lastCycle && pageHit);
  assign accept    = reqValid && reqReady;
  // an accept while the strobes are low is by definition a page hit
  assign pulseLen  = activeQ ? cfgNextPulse : cfgFirstPulse;
  assign loadVal   = (pulseLen == '0) ? '0 : pulseLen - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
    end else if (accept) begin
      activeQ <= 1'b1;
      cntQ    <= loadVal;
    end else if (lastCycle) begin
      activeQ <= 1'b0;
    end else if (activeQ) begin
      cntQ    <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.capture = lastCycle;
    strb.active  = activeQ;
  end

  // R3 R4: a running access counts down one per clock without dropping the strobes
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && cntQ != '0) |=> (activeQ && cntQ == $past(cntQ) - 1'b1));

  // R7: strobes released after a final clock unless the next request was taken
  assert_release_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lastCycle && !accept) |=> !activeQ);

  // R6: a zero setting still yields an access (counter starts at zero)
  assert_zero_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pulseLen == '0) |=> (activeQ && cntQ == '0));
endmodule

// File: rtl/pmrd_dpath.sv
module pmrd_dpath
  import pmrd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 2,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrb_t           strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic                cfgByteSel,
  input  logic [DATA_W-1:0]   memData,
  output logic                pageHit,
  output logic                csN,
  output logic                rdN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] bsN,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);
  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [BE_W-1:0]   selQ;

  assign pageHit = (reqAddr[ADDR_W-1:PAGE_BITS] == addrQ[ADDR_W-1:PAGE_BITS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      selQ  <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      selQ  <= cfgByteSel ? reqByteEn : {BE_W{1'b1}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) rspData <= memData;
    end
  end

  // both strobes share one waveform in page mode
  assign csN     = ~strb.active;
  assign rdN     = ~strb.active;
  assign memAddr = addrQ;
  assign bsN     = strb.active ? ~selQ : {BE_W{1'b1}};

  // R10: every response follows a final clock of an access
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $past(strb.capture));

  // R4: a load during a running access only ever comes with a matching page
  assert_hit_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.active) |-> pageHit);

  // R9: no byte line active while the strobes are high
  assert_bs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> (&bsN));

  // R8: the address bus holds steady within a single access
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb.active) && $past(!strb.capture)) |-> $stable(memAddr));
endmodule

// File: rtl/pmrd_seq.sv
module pmrd_seq
  import pmrd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 2,
  parameter int DATA_W    = 16,
  parameter int PULSE_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [PULSE_W-1:0]  cfgFirstPulse,
  input  logic [PULSE_W-1:0]  cfgNextPulse,
  input  logic                cfgByteSel,
  output logic                csN,
  output logic                rdN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] bsN,
  input  logic [DATA_W-1:0]   memData,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);
  ctrlStrb_t strb;
  logic      pageHit;

  pmrd_ctrl #(.PULSE_W(PULSE_W)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqValid      (reqValid),
    .pageHit       (pageHit),
    .cfgFirstPulse (cfgFirstPulse),
    .cfgNextPulse  (cfgNextPulse),
    .reqReady      (reqReady),
    .strb          (strb)
  );

  pmrd_dpath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqByteEn  (reqByteEn),
    .cfgByteSel (cfgByteSel),
    .memData    (memData),
    .pageHit    (pageHit),
    .csN        (csN),
    .rdN        (rdN),
    .memAddr    (memAddr),
    .bsN        (bsN),
    .rspValid   (rspValid),
    .rspData    (rspData)
  );

  // R2: one waveform on both strobes
  assert_strobe_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csN == rdN);
endmodule

// File: tb/pmrd_seq_tb.sv
module pmrd_seq_tb_top;
  localparam int ADDR_W = 16, PAGE_BITS = 2, DATA_W = 16, PULSE_W = 6;
  localparam int BE_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [BE_W-1:0] reqByteEn = '0;
  logic [PULSE_W-1:0] cfgFirstPulse = 6'd4;
  logic [PULSE_W-1:0] cfgNextPulse = 6'd2;
  logic cfgByteSel = 1'b1;
  logic csN, rdN, rspValid;
  logic [ADDR_W-1:0] memAddr;
  logic [BE_W-1:0] bsN;
  logic [DATA_W-1:0] memData, rspData;

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] memFn(logic [ADDR_W-1:0] a);
    return (a * 16'd7) ^ 16'h3C5A;
  endfunction

  // memory model: drives data only while the read strobe is low
  assign memData = rdN ? '0 : memFn(memAddr);

  pmrd_seq #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W), .PULSE_W(PULSE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .cfgFirstPulse(cfgFirstPulse),
    .cfgNextPulse(cfgNextPulse), .cfgByteSel(cfgByteSel), .csN(csN), .rdN(rdN),
    .memAddr(memAddr), .bsN(bsN), .memData(memData), .rspValid(rspValid), .rspData(rspData)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   bs;
    int                len;
    bit                hit;
    string             tag;
  } item_t;

  item_t expQ[$];
  int nCmp = 0, nBad = 0;
  bit havePrev = 0;
  logic [ADDR_W-1:0] prevAddr = '0;
  bit monOn = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic setCfg(int first, int nxt, bit bsel);
    cfgFirstPulse = PULSE_W'(first);
    cfgNextPulse  = PULSE_W'(nxt);
    cfgByteSel    = bsel;
  endtask

  // driver: offers one request, pushes the expected result at acceptance
  task automatic sendReq(logic [ADDR_W-1:0] a, logic [BE_W-1:0] be, int gap, string tag);
    item_t it;
    bit hit;
    int f, n;
    @(negedge clk);
    if (gap > 0) begin
      reqValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    hit = havePrev && (gap == 0) &&
          (a[ADDR_W-1:PAGE_BITS] == prevAddr[ADDR_W-1:PAGE_BITS]);
    f = (cfgFirstPulse == 0) ? 1 : int'(cfgFirstPulse);
    n = (cfgNextPulse == 0) ? 1 : int'(cfgNextPulse);
    reqValid = 1'b1; reqAddr = a; reqByteEn = be;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    it.addr = a;
    it.bs   = cfgByteSel ? ~be : '0;
    it.len  = hit ? n : f;
    it.hit  = hit;
    it.tag  = tag;
    expQ.push_back(it);
    havePrev = 1; prevAddr = a;
    @(posedge clk);
  endtask

  task automatic idle(int cyc);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  // monitor: measures every low run of the strobes and compares on each response
  int segLen = 0;
  bit fell = 0;
  logic prevCsN = 1'b1;
  logic [ADDR_W-1:0] segAddr = '0;
  logic [BE_W-1:0] segBs = '0;

  always @(negedge clk) begin
    if (monOn) begin
      check(csN == rdN, "R2", "strobe pair", rdN, csN);
      if (csN) check(bsN == '1, "R9", "idle byte selects", bsN, '1);
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check(0, "R10", "unexpected response", rspData, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(rspData == memFn(it.addr), "R10", "read data", rspData, memFn(it.addr));
          check(segLen == it.len, it.tag, "pulse length", segLen, it.len);
          check(segAddr == it.addr, "R8", "address bus", segAddr, it.addr);
          check(segBs == it.bs, "R9", "byte selects", segBs, it.bs);
          check(fell == !it.hit, it.hit ? "R2" : "R7", "strobe rose before access",
                fell, !it.hit);
        end
        segLen = csN ? 0 : 1;
        fell = 0;
      end else if (!csN) begin
        if (prevCsN) begin
          fell = 1;
          segLen = 0;
        end
        segLen++;
      end
      if (!csN) begin
        segAddr = memAddr;
        segBs = bsN;
      end
      prevCsN = csN;
    end
  end

  // watchdog
  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R10", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && rdN == 1'b1, "R1", "strobes in reset", {csN, rdN}, 2'b11);
    check(bsN == '1, "R1", "byte selects in reset", bsN, '1);
    check(rspValid == 1'b0, "R1", "rspValid in reset", rspValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    monOn = 1;

    // burst inside one page, then a page change while busy
    setCfg(4, 2, 1);
    sendReq(16'h0100, 2'b11, 0, "R3");
    sendReq(16'h0101, 2'b01, 0, "R4");
    sendReq(16'h0102, 2'b10, 0, "R4");
    sendReq(16'h0103, 2'b11, 0, "R4");
    sendReq(16'h0105, 2'b01, 0, "R7");
    sendReq(16'h0106, 2'b10, 0, "R4");
    idle(20);

    // subsequent pulse longer than the first one
    setCfg(2, 6, 1);
    sendReq(16'h0200, 2'b11, 1, "R3");
    sendReq(16'h0201, 2'b10, 0, "R5");
    sendReq(16'h0202, 2'b01, 0, "R5");
    idle(20);

    // zero settings, all bytes selected
    setCfg(0, 0, 0);
    sendReq(16'h0300, 2'b01, 1, "R6");
    sendReq(16'h0301, 2'b10, 0, "R6");
    sendReq(16'h0302, 2'b00, 0, "R6");
    idle(20);

    // same page after a gap is a new page; mixed hits and misses
    setCfg(3, 1, 1);
    sendReq(16'h0410, 2'b11, 1, "R3");
    sendReq(16'h0411, 2'b01, 5, "R7");
    sendReq(16'h0412, 2'b10, 0, "R4");
    sendReq(16'h0422, 2'b11, 0, "R7");
    sendReq(16'h0423, 2'b01, 0, "R4");
    sendReq(16'h0000, 2'b10, 0, "R7");
    idle(20);

    // single-clock pulses, full page then next page
    setCfg(1, 1, 1);
    sendReq(16'h0500, 2'b11, 1, "R3");
    sendReq(16'h0501, 2'b01, 0, "R4");
    sendReq(16'h0502, 2'b10, 0, "R4");
    sendReq(16'h0503, 2'b11, 0, "R4");
    sendReq(16'h0504, 2'b01, 0, "R7");
    idle(30);

    check(expQ.size() == 0, "R10", "responses outstanding", expQ.size(), 0);
    check(csN == 1'b1, "R7", "strobes released at end", csN, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule